// File: doc/BRIEF.md
# Selectable CRC-16 and Character Parity Checker

This unit detects errors for a synchronous serial receiver and transmitter. A three-bit mode input chooses one of four behaviours: a CRC-16 check, an odd parity check, an even parity check, or no checking at all. Characters arrive one bit per strobe. On transmit, the same unit supplies the running CRC value and the parity bit that goes after the data bits of the current character.

How the single error flag is raised depends on the protocol class. With bit-oriented framing, the flag marks a CRC mismatch at end of message. With character-oriented framing in CRC mode, it marks an all-zero CRC register at the end of each character. In parity modes, it marks each character whose parity is wrong. Software clears the flag by reading status, and disabling the receiver also clears it.

The CRC is shifted MSB first with polynomial x^16 + x^15 + x^2 + 1 and a zero starting value. There is no final inversion, so a message followed by its own check value leaves the register at zero. Mode codes: 001 = CRC-16, 011 = odd parity, 100 = even parity, 111 = checking inhibited. Codes 000, 010, 101 and 110 are unused and behave like 111.

Top module: `errchk_unit`

## Requirements
- R1: In mode 001 each strobed bit b updates the register as c' = {c[14:0],0} XOR (c[15]^b ? 16'h8005 : 0), and crc_out shows the register. A start-of-message strobe sets it to zero and ignores a bit in the same cycle. With no strobe, crc_out holds.
- R2: In mode 001 with bit_proto=1, an end-of-message strobe sets err_chk on the next edge when the register differs from zero. Any bit strobed in that same cycle is included. A message followed by its own 16 check bits sent MSB first gives no error.
- R3: In mode 001 with bit_proto=0, an end-of-character strobe sets err_chk when the register is all zeros, including any bit strobed in that cycle.
- R4: With bit_proto=0, strip_sync=1 and sync_char=1, strobed bits leave the CRC unchanged and an end-of-character strobe does not set err_chk. With strip_sync=0, sync characters enter the CRC.
- R5: In mode 011 or 100, an end-of-character strobe sets err_chk when the number of ones in the character is wrong. The count covers every bit strobed since the last end-of-character or start-of-message, parity bit included, and must be odd for 011 and even for 100. The count restarts after each end-of-character.
- R6: par_out is the parity bit for the bits strobed so far in the current character. In mode 011 it is 1 when their count of ones is even. In mode 100 it is 1 when the count is odd. In every other mode it is 0.
- R7: In modes 111, 000, 010, 101 and 110, err_chk never becomes set, and crc_out only changes through start-of-message.
- R8: stat_rd clears err_chk on the next edge. If a set condition occurs in the same cycle, the set wins.
- R9: While rx_en=0, err_chk is cleared on the next edge and cannot be set.
- R10: After reset, err_chk=0 and crc_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Check selection code |
| bit_proto | input | 1 | 1 = bit-oriented framing, 0 = character-oriented |
| strip_sync | input | 1 | Leave sync characters out of the CRC (character-oriented) |
| sync_char | input | 1 | Current character is a sync character |
| rx_en | input | 1 | Receiver enable; low clears the flag |
| stat_rd | input | 1 | Status read strobe; clears the flag |
| som | input | 1 | Start-of-message strobe |
| bit_vld | input | 1 | Serial bit strobe |
| bit_in | input | 1 | Serial data bit |
| eoc | input | 1 | End-of-character strobe |
| eom | input | 1 | End-of-message strobe |
| err_chk | output | 1 | Error-check flag |
| crc_out | output | 16 | Current CRC register, for transmit |
| par_out | output | 1 | Parity bit for the current character, for transmit |

## Verification
The assertions take the strobes as single-cycle events. They do not assume that end-of-message and end-of-character are exclusive. The read-clear property is therefore stated only for cycles without either end strobe, since the set can take precedence there. The stimulus drives each strobe for exactly one cycle, changes the mode only between characters, and sends 8-bit characters (7 data bits plus parity in the parity modes). This keeps character-oriented CRC use within its 8-bit restriction.

// File: rtl/errchk_pkg.sv
package errchk_pkg;
   localparam logic [2:0] CK_CRC  = 3'b001;
   localparam logic [2:0] CK_ODD  = 3'b011;
   localparam logic [2:0] CK_EVEN = 3'b100;

   typedef struct packed {
      logic crc_on;
      logic par_on;
      logic par_odd;
   } chk_sel_t;
endpackage

// File: rtl/errchk_dec.sv
module errchk_dec
   import errchk_pkg::*;
#(
   parameter int MODE_W = 3
) (
   input  logic [MODE_W-1:0] mode,
   output chk_sel_t          sel
);
   if (MODE_W != 3) begin : g_bad_w
      $error("errchk_dec: MODE_W must be 3");
   end

   always_comb begin
      sel = '0;
      unique case (mode)
         CK_CRC:  sel.crc_on = 1'b1;
         CK_ODD:  begin sel.par_on = 1'b1; sel.par_odd = 1'b1; end
         CK_EVEN: sel.par_on = 1'b1;
         default: sel = '0;
      endcase
   end
endmodule

// File: rtl/errchk_crc.sv
module errchk_crc #(
   parameter int            W    = 16,
   parameter logic [W-1:0]  POLY = 16'h8005,
   parameter logic [W-1:0]  INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic         din,
   output logic [W-1:0] crc_q,
   output logic [W-1:0] crc_nx
);
   if (W < 2) begin : g_bad_w
      $error("errchk_crc: W must be at least 2");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("errchk_crc: polynomial must have a constant term");
   end

   logic         fb;
   logic [W-1:0] shifted;

   assign fb = crc_q[W-1] ^ din;

   for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         assign shifted[i] = POLY[0] & fb;
      end else begin : g_up
         assign shifted[i] = crc_q[i-1] ^ (POLY[i] & fb);
      end
   end

   assign crc_nx = step ? shifted : crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= INIT;
      else if (clr) crc_q <= INIT;
      else          crc_q <= crc_nx;
   end
endmodule

// File: rtl/errchk_par.sv
module errchk_par (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic restart,
   input  logic step,
   input  logic din,
   output logic acc_q,
   output logic acc_nx
);
   assign acc_nx = step ? (acc_q ^ din) : acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              acc_q <= 1'b0;
      else if (clr || restart) acc_q <= 1'b0;
      else                     acc_q <= acc_nx;
   end
endmodule

// File: rtl/errchk_unit.sv
module errchk_unit
   import errchk_pkg::*;
#(
   parameter int           MODE_W  = 3,
   parameter int           CRC_W   = 16,
   parameter logic [15:0]  POLY    = 16'h8005,
   parameter logic [15:0]  INIT    = 16'h0000,
   parameter logic [15:0]  RESIDUE = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic              bit_proto,
   input  logic              strip_sync,
   input  logic              sync_char,
   input  logic              rx_en,
   input  logic              stat_rd,
   input  logic              som,
   input  logic              bit_vld,
   input  logic              bit_in,
   input  logic              eoc,
   input  logic              eom,
   output logic              err_chk,
   output logic [CRC_W-1:0]  crc_out,
   output logic              par_out
);
   if (CRC_W != 16) begin : g_bad_w
      $error("errchk_unit: CRC_W must be 16");
   end

   chk_sel_t         sel;
   logic             stripped;
   logic             crc_step, par_step;
   logic [CRC_W-1:0] crc_q, crc_nx;
   logic             acc_q, acc_nx;
   logic             ev_bo, ev_co, ev_par, set_err;

   errchk_dec #(.MODE_W(MODE_W)) i_dec (.mode(mode), .sel(sel));

   assign stripped = !bit_proto && strip_sync && sync_char;
   assign crc_step = bit_vld && sel.crc_on && !stripped;
   assign par_step = bit_vld && sel.par_on;

   errchk_crc #(.W(CRC_W), .POLY(POLY), .INIT(INIT)) i_crc (
      .clk(clk), .rst_n(rst_n), .clr(som), .step(crc_step), .din(bit_in),
      .crc_q(crc_q), .crc_nx(crc_nx));

   errchk_par i_par (
      .clk(clk), .rst_n(rst_n), .clr(som), .restart(eoc), .step(par_step),
      .din(bit_in), .acc_q(acc_q), .acc_nx(acc_nx));

   assign ev_bo  = sel.crc_on && bit_proto && eom && !som && (crc_nx != RESIDUE);
   assign ev_co  = sel.crc_on && !bit_proto && eoc && !som && !stripped
                   && (crc_nx == '0);
   assign ev_par = sel.par_on && eoc && !som
                   && (sel.par_odd ? !acc_nx : acc_nx);
   assign set_err = rx_en && (ev_bo || ev_co || ev_par);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_chk <= 1'b0;
      else if (!rx_en)  err_chk <= 1'b0;
      else if (set_err) err_chk <= 1'b1;
      else if (stat_rd) err_chk <= 1'b0;
   end

   assign crc_out = crc_q;
   assign par_out = sel.par_on && (sel.par_odd ? !acc_q : acc_q);
endmodule

// File: rtl/errchk_chk.sv
module errchk_chk #(
   parameter logic [15:0] INIT = 16'h0000
) (
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  mode,
   input logic        rx_en,
   input logic        stat_rd,
   input logic        som,
   input logic        bit_vld,
   input logic        eoc,
   input logic        eom,
   input logic        err_chk,
   input logic [15:0] crc_out
);
   logic checking;
   assign checking = (mode == 3'b001) || (mode == 3'b011) || (mode == 3'b100);

   AST_SOM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      som |=> crc_out == INIT);                                   // R1
   AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_vld && !som) |=> $stable(crc_out));                    // R1
   AST_OFF_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (!checking && !err_chk) |=> !err_chk);                       // R7
   AST_OFF_CRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 3'b001 && !som) |=> $stable(crc_out));              // R7
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !eoc && !eom) |=> !err_chk);                     // R8
   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !err_chk);                                        // R9
endmodule

bind errchk_unit errchk_chk #(.INIT(INIT)) i_errchk_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .rx_en(rx_en), .stat_rd(stat_rd),
   .som(som), .bit_vld(bit_vld), .eoc(eoc), .eom(eom), .err_chk(err_chk),
   .crc_out(crc_out));

// File: tb/test_errchk_unit.sv
module test_errchk_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode = 3'b001;
   logic        bit_proto = 1'b1, strip_sync = 1'b0, sync_char = 1'b0;
   logic        rx_en = 1'b1, stat_rd = 1'b0, som = 1'b0;
   logic        bit_vld = 1'b0, bit_in = 1'b0, eoc = 1'b0, eom = 1'b0;
   logic        err_chk, par_out;
   logic [15:0] crc_out;

   int checks = 0;
   int failures = 0;
   logic [15:0] ref_crc;

   always #2 clk = ~clk;

   errchk_unit i_errchk_unit (
      .clk(clk), .rst_n(rst_n), .mode(mode), .bit_proto(bit_proto),
      .strip_sync(strip_sync), .sync_char(sync_char), .rx_en(rx_en),
      .stat_rd(stat_rd), .som(som), .bit_vld(bit_vld), .bit_in(bit_in),
      .eoc(eoc), .eom(eom), .err_chk(err_chk), .crc_out(crc_out),
      .par_out(par_out));

   // {mode, 8-bit character incl. parity, expected err}
   localparam logic [11:0] VEC [10] = '{
      {3'b011, 8'h01, 1'b0}, {3'b011, 8'h03, 1'b1}, {3'b011, 8'hFF, 1'b1},
      {3'b011, 8'h7F, 1'b0}, {3'b100, 8'h03, 1'b0}, {3'b100, 8'h01, 1'b1},
      {3'b100, 8'h00, 1'b0}, {3'b100, 8'hFE, 1'b1}, {3'b111, 8'h01, 1'b0},
      {3'b010, 8'h03, 1'b0}};

   function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
      logic fb;
      fb = c[15] ^ b;
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h8005;
      return c;
   endfunction

   function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
      for (int i = 7; i >= 0; i--) c = crc_bit(c, d[i]);
      return c;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      bit_vld = 1'b1; bit_in = b;
      @(negedge clk);
      bit_vld = 1'b0; bit_in = 1'b0;
   endtask

   task automatic send_bits(input logic [15:0] d, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(d[i]);
   endtask

   task automatic pulse_som();  som = 1'b1;  @(negedge clk); som = 1'b0;  endtask
   task automatic pulse_eoc();  eoc = 1'b1;  @(negedge clk); eoc = 1'b0;  endtask
   task automatic pulse_eom();  eom = 1'b1;  @(negedge clk); eom = 1'b0;  endtask
   task automatic pulse_rd();   stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 err after reset", err_chk, 0);
      chk("R10 crc after reset", crc_out, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // parity vector table: R5, R7
      foreach (VEC[k]) begin
         mode = VEC[k][11:9];
         pulse_som();
         send_bits({8'h00, VEC[k][8:1]}, 8);
         pulse_eoc();
         chk($sformatf("R5 vec %0d err", k), err_chk, VEC[k][0]);
         pulse_rd();
      end

      // R5 restart after end-of-character
      mode = 3'b011; pulse_som();
      send_bits(16'h0003, 8); pulse_eoc();
      chk("R5 first char err", err_chk, 1);
      pulse_rd();
      chk("R8 read clears", err_chk, 0);
      send_bits(16'h0001, 8); pulse_eoc();
      chk("R5 restart second char err", err_chk, 0);

      // R6 transmit parity bit
      pulse_som();
      send_bits(16'h0050, 7);
      #1 chk("R6 odd par_out", par_out, 1);
      mode = 3'b100;
      #1 chk("R6 even par_out", par_out, 0);
      mode = 3'b001;
      #1 chk("R6 crc mode par_out", par_out, 0);
      mode = 3'b011;
      @(negedge clk);
      send_bit(1'b1); pulse_eoc();
      chk("R6 appended parity accepted", err_chk, 0);

      // R1, R2 bit-oriented CRC
      mode = 3'b001; bit_proto = 1'b1;
      pulse_som();
      chk("R1 som clears", crc_out, 0);
      send_bits(16'h0031, 8); send_bits(16'h0032, 8);
      ref_crc = crc_byte(crc_byte(16'h0000, 8'h31), 8'h32);
      chk("R1 crc value", crc_out, ref_crc);
      send_bits(ref_crc, 16);
      chk("R2 residue zero", crc_out, 0);
      pulse_eom();
      chk("R2 good message", err_chk, 0);
      pulse_som();
      send_bits(16'h0031, 8); send_bits(16'h0032, 8);
      send_bits(ref_crc ^ 16'h0100, 16);
      pulse_eom();
      chk("R2 corrupted message", err_chk, 1);
      pulse_rd();

      // R8 set wins over read
      pulse_som(); send_bits(16'h0031, 8);
      eom = 1'b1; stat_rd = 1'b1; @(negedge clk); eom = 1'b0; stat_rd = 1'b0;
      chk("R8 set wins", err_chk, 1);

      // R9 receiver disable
      rx_en = 1'b0; @(negedge clk);
      chk("R9 disable clears", err_chk, 0);
      pulse_eom();
      chk("R9 no set while disabled", err_chk, 0);
      rx_en = 1'b1;

      // R3 character-oriented CRC
      bit_proto = 1'b0;
      pulse_som(); send_bits(16'h0000, 8); pulse_eoc();
      chk("R3 zero register flags", err_chk, 1);
      pulse_rd();
      pulse_som(); send_bits(16'h0031, 8); pulse_eoc();
      chk("R3 nonzero register", err_chk,
          (crc_byte(16'h0000, 8'h31) == 16'h0000) ? 1 : 0);

      // R4 sync stripping
      strip_sync = 1'b1; sync_char = 1'b1;
      pulse_som(); send_bits(16'h0031, 8); pulse_eoc();
      chk("R4 stripped crc", crc_out, 0);
      chk("R4 stripped no flag", err_chk, 0);
      strip_sync = 1'b0;
      pulse_som(); send_bits(16'h0031, 8);
      chk("R4 unstripped crc", crc_out, crc_byte(16'h0000, 8'h31));
      sync_char = 1'b0;

      // R7 inhibited / unused modes
      bit_proto = 1'b1;
      pulse_som(); send_bits(16'h0031, 8);
      mode = 3'b111;
      send_bits(16'h0055, 8);
      chk("R7 crc frozen 111", crc_out, crc_byte(16'h0000, 8'h31));
      pulse_eom();
      chk("R7 no err 111", err_chk, 0);
      mode = 3'b000;
      send_bits(16'h00A5, 8); pulse_eom();
      chk("R7 crc frozen 000", crc_out, crc_byte(16'h0000, 8'h31));
      chk("R7 no err 000", err_chk, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule